// File: doc/BRIEF.md
# Multi-Endpoint Slave FIFO Port

This block is the slave end of a parallel FIFO port that an external master drives. One shared port reaches four endpoint FIFOs, chosen by a 2-bit address. The master writes data words, reads them back, and closes a packet with a packet-end strobe. Every strobe and the output enable are gated by a select input. Data written into an endpoint becomes readable only once a packet-end commits it, so a short packet of any length can be handed over. Each endpoint is configured as byte wide or word wide.

The port runs in one of two modes. In synchronous mode the strobes qualify the interface clock, and each rising edge with a strobe active performs one transfer. In asynchronous mode the strobes are free-running pulses. Each one passes through a two-flop synchronizer, and its deasserting edge performs exactly one transfer. The empty and full flags of the addressed endpoint are registered on the interface clock. The data bus drive enable is a separate output.

Top module: `sfifo_port`

## Requirements
- R1: The 2-bit address picks the one endpoint that a read, write or packet-end acts on. The other endpoints keep their contents and flags.
- R2: While select is low, the read, write and packet-end strobes have no effect, and the data bus enable stays low.
- R3: The data bus enable is high exactly when select and output enable are both high. The conflict output is high when select, output enable and write are all high in the same cycle. The data output is zero while the enable is low.
- R4: In synchronous mode, each rising edge with select and write high stores one word in the addressed endpoint. A write to an endpoint that already holds DEPTH words is ignored.
- R5: In synchronous mode, each rising edge with select and read high removes one committed word, and the data output then shows the next word. A read when no committed word is present moves nothing.
- R6: Words that have been written but not committed cannot be read, and the empty flag stays high until they are committed. A packet-end commits every word written so far, including a word written on the same edge.
- R7: On an endpoint whose width bit is 0 (bit n of ep_wide belongs to endpoint n), only bits [7:0] are stored, and bits [15:8] of the data output read as zero. When the bit is 1, all 16 bits are kept.
- R8: After each rising edge, empty is high when the addressed endpoint holds no committed word, and full is high when it holds DEPTH words. Both flags show the state left by that edge, for the address applied at that edge. Reset sets empty to 1 and full to 0.
- R9: In asynchronous mode, the deasserting edge of each strobe performs one transfer, after two synchronizing flops. The transfer lands on the third rising edge after the strobe falls, whatever the length of the strobe. Address and data must be held stable over that window.
- R10: No endpoint ever holds more than DEPTH words, and no endpoint ever holds more committed words than written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset |
| async_mode | input | 1 | 1 = strobes are asynchronous pulses |
| ep_wide | input | 4 | Per-endpoint width, 1 = 16 bits, 0 = 8 bits |
| sel | input | 1 | Select, gates all strobes and the output enable |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| oe | input | 1 | Output enable request |
| pend | input | 1 | Packet-end strobe, commits written data |
| addr | input | 2 | Endpoint address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, head of the addressed endpoint |
| dout_en | output | 1 | Data bus drive enable |
| oe_conflict | output | 1 | Write attempted while the bus is enabled |
| empty | output | 1 | Registered empty flag of the addressed endpoint |
| full | output | 1 | Registered full flag of the addressed endpoint |

## Verification
A write and a packet-end can fall on the same clock edge. A read can also land on that edge, so committing, storing and removing all change the counts at once. Directed cycles force a write and a packet-end together, and also a write into a full endpoint together with a commit. Random cycles then mix all three strobes on one edge. Each case is judged by a bench queue model that applies the write, then the read, then the commit. The empty flag and the data read back must match that model.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  // Count after one cycle of optional increment and decrement.
  function automatic int cnt_step(int c, logic inc, logic dec);
    return c + int'(inc) - int'(dec);
  endfunction

  // Circular pointer advance.
  function automatic int ptr_next(int p, int depth);
    return (p + 1) % depth;
  endfunction

  // Keep only the low byte when the lane is narrow.
  function automatic logic [31:0] lane_fit(logic [31:0] d, logic wide);
    return wide ? d : {24'd0, d[7:0]};
  endfunction
endpackage

// File: rtl/sfp_edge_sync.sv
module sfp_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= strobe_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall_o = s3 & ~s2;

  // R9: a detected edge is a single-cycle event
  p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sfp_ep_fifo.sv
module sfp_ep_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          do_wr,
  input  logic [DW-1:0] wdata,
  input  logic          do_rd,
  input  logic          do_commit,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] tot_o,
  output logic [CW-1:0] tot_nxt,
  output logic [CW-1:0] cmt_nxt
);
  import sfp_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] tot, cmt;
  logic          wr_ok, rd_ok, wr_drop, rd_drop;

  assign wr_ok   = do_wr && (tot != CW'(DEPTH));
  assign rd_ok   = do_rd && (cmt != '0);
  assign wr_drop = do_wr && !wr_ok;
  assign rd_drop = do_rd && !rd_ok;

  assign tot_nxt = CW'(cnt_step(int'(tot), wr_ok, rd_ok));
  assign cmt_nxt = do_commit ? tot_nxt : CW'(cnt_step(int'(cmt), 1'b0, rd_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      tot  <= '0;
      cmt  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_ok) begin
        mem[wptr] <= DW'(lane_fit(32'(wdata), wide));
        wptr      <= AW'(ptr_next(int'(wptr), DEPTH));
      end
      if (rd_ok) rptr <= AW'(ptr_next(int'(rptr), DEPTH));
      tot <= tot_nxt;
      cmt <= cmt_nxt;
    end
  end

  assign rdata = DW'(lane_fit(32'(mem[rptr]), wide));
  assign tot_o = tot;

  // R10: occupancy bounds
  p_tot_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tot <= CW'(DEPTH));
  p_cmt_le_tot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmt <= tot);
  // R4: write into a full endpoint leaves occupancy untouched
  p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && !do_rd) |=> $stable(tot));
  // R5: read with nothing committed does not move the read pointer
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drop |=> $stable(rptr));
  // R7: narrow endpoint presents zero upper byte
  p_byte_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (rdata[DW-1:8] == '0));
endmodule

// File: rtl/sfifo_port.sv
module sfifo_port #(
  parameter int EPW   = 2,
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int NUM_EP = 1 << EPW,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              async_mode,
  input  logic [NUM_EP-1:0] ep_wide,
  input  logic              sel,
  input  logic              rd,
  input  logic              wr,
  input  logic              oe,
  input  logic              pend,
  input  logic [EPW-1:0]    addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              dout_en,
  output logic              oe_conflict,
  output logic              empty,
  output logic              full
);
  // strobe order: 0 read, 1 write, 2 packet-end
  logic [2:0]       gated, as_fall, op;
  logic [EPW-1:0]   addr_s1, addr_s2, op_addr;
  logic [DW-1:0]    din_s1, din_s2, op_din;
  logic [DW-1:0]    rdata_a   [NUM_EP];
  logic [CW-1:0]    tot_a     [NUM_EP];
  logic [CW-1:0]    tot_nxt_a [NUM_EP];
  logic [CW-1:0]    cmt_nxt_a [NUM_EP];
  logic [NUM_EP*CW-1:0] tot_flat;

  assign gated = {pend, wr, rd} & {3{sel}};

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_sync
      sfp_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (gated[g]),
        .fall_o   (as_fall[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_s1 <= '0;
      addr_s2 <= '0;
      din_s1  <= '0;
      din_s2  <= '0;
    end else begin
      addr_s1 <= addr;
      addr_s2 <= addr_s1;
      din_s1  <= din;
      din_s2  <= din_s1;
    end
  end

  assign op      = async_mode ? as_fall : gated;
  assign op_addr = async_mode ? addr_s2 : addr;
  assign op_din  = async_mode ? din_s2  : din;

  generate
    for (g = 0; g < NUM_EP; g++) begin : g_ep
      logic hit;
      assign hit = (op_addr == EPW'(g));
      sfp_ep_fifo #(.DEPTH(DEPTH), .DW(DW)) u_ep (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide      (ep_wide[g]),
        .do_wr     (hit && op[1]),
        .wdata     (op_din),
        .do_rd     (hit && op[0]),
        .do_commit (hit && op[2]),
        .rdata     (rdata_a[g]),
        .tot_o     (tot_a[g]),
        .tot_nxt   (tot_nxt_a[g]),
        .cmt_nxt   (cmt_nxt_a[g])
      );
      assign tot_flat[g*CW +: CW] = tot_a[g];
    end
  endgenerate

  assign dout_en     = sel & oe;
  assign oe_conflict = sel & oe & wr;
  assign dout        = dout_en ? rdata_a[addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      empty <= (cmt_nxt_a[addr] == '0);
      full  <= (tot_nxt_a[addr] == CW'(DEPTH));
    end
  end

  // R2: unselected synchronous cycles change no endpoint
  p_nosel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && !sel) |=> $stable(tot_flat));
  // R3: bus drive implies select
  p_oe_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> sel);
  // R3: undriven bus reads zero
  p_dout_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));
  // R8: an endpoint cannot be both empty of words and full
  p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty && $past(cmt_nxt_a[addr]) == $past(tot_nxt_a[addr])));
endmodule

// File: tb/sfifo_port_test.sv
module sfifo_port_test;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic async_mode = 1'b0;
  logic [3:0] ep_wide = 4'b0101;
  logic sel = 0, rd = 0, wr = 0, oe = 0, pend = 0;
  logic [1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic dout_en, oe_conflict, empty, full;

  int checks = 0;
  int errors = 0;

  logic [15:0] mmem [4][D];
  int wp[4], rp[4], tot[4], cmt[4];

  always #2 clk = ~clk;

  sfifo_port uut (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .ep_wide(ep_wide),
    .sel(sel), .rd(rd), .wr(wr), .oe(oe), .pend(pend), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .oe_conflict(oe_conflict),
    .empty(empty), .full(full)
  );

  function automatic logic [15:0] fit(logic [15:0] d, int a);
    return ep_wide[a] ? d : {8'h00, d[7:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // model: write, then read, then commit
  task automatic model_op(int a, bit r, bit w, bit p, logic [15:0] d);
    bit wok, rok;
    wok = w && tot[a] < D;
    rok = r && cmt[a] > 0;
    if (wok) begin mmem[a][wp[a]] = fit(d, a); wp[a] = (wp[a] + 1) % D; end
    if (rok) rp[a] = (rp[a] + 1) % D;
    tot[a] = tot[a] + int'(wok) - int'(rok);
    if (p) cmt[a] = tot[a]; else cmt[a] = cmt[a] - int'(rok);
  endtask

  // one cycle, entered and left at a falling edge
  task automatic cyc(bit s, bit r, bit w, bit o, bit p, int a, logic [15:0] d);
    sel = s; rd = r; wr = w; oe = o; pend = p; addr = 2'(a); din = d;
    #1;
    chk(dout_en == (s & o), "R3", "dout_en", int'(dout_en), int'(s & o));
    chk(oe_conflict == (s & o & w), "R3", "oe_conflict", int'(oe_conflict), int'(s & o & w));
    if (s && o && cmt[a] > 0)
      chk(dout == mmem[a][rp[a]], "R5", "dout head", int'(dout), int'(mmem[a][rp[a]]));
    if (!(s && o))
      chk(dout == 16'h0, "R3", "idle dout", int'(dout), 0);
    @(posedge clk);
    if (!async_mode && s) model_op(a, r, w, p, d);
    @(negedge clk);
    chk(empty == (cmt[a] == 0), "R8", "empty", int'(empty), int'(cmt[a] == 0));
    chk(full == (tot[a] == D), "R8", "full", int'(full), int'(tot[a] == D));
  endtask

  // asynchronous strobe: kind 0 read, 1 write, 2 packet-end
  task automatic astrobe(int kind, int a, logic [15:0] d, int hi);
    for (int i = 0; i < hi; i++)
      cyc(1, kind == 0, kind == 1, 0, kind == 2, a, d);
    cyc(1, 0, 0, 0, 0, a, d);
    cyc(1, 0, 0, 0, 0, a, d);
    model_op(a, kind == 0, kind == 1, kind == 2, d);
    cyc(1, 0, 0, 0, 0, a, d);
    cyc(1, 0, 0, 1, 0, a, d);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    for (int a = 0; a < 4; a++) begin
      wp[a] = 0; rp[a] = 0; tot[a] = 0; cmt[a] = 0;
      for (int i = 0; i < D; i++) mmem[a][i] = '0;
    end
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state, R8
    chk(empty == 1'b1, "R8", "reset empty", int'(empty), 1);
    chk(full == 1'b0, "R8", "reset full", int'(full), 0);
    chk(dout_en == 1'b0, "R3", "reset dout_en", int'(dout_en), 0);

    // R6: uncommitted words stay invisible; R7 byte endpoint 1
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, 0, 1, 16'hA5C0 + 16'(i));
    chk(empty == 1'b1, "R6", "empty before commit", int'(empty), 1);
    cyc(1, 1, 0, 1, 0, 1, 0);
    cyc(1, 0, 0, 0, 1, 1, 0);
    chk(empty == 1'b0, "R6", "empty after commit", int'(empty), 0);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 0, 1, 0, 1, 0);
      chk(dout == 16'h00C0 + 16'(i), "R7", "byte lane data", int'(dout), 16'h00C0 + i);
      cyc(1, 1, 0, 1, 0, 1, 0);
    end
    chk(empty == 1'b1, "R5", "drained", int'(empty), 1);

    // R6: write and packet-end on the same edge, wide endpoint 0
    cyc(1, 0, 1, 0, 1, 0, 16'hBEEF);
    chk(empty == 1'b0, "R6", "same-edge commit", int'(empty), 0);
    cyc(1, 0, 0, 1, 0, 0, 0);
    chk(dout == 16'hBEEF, "R7", "wide lane data", int'(dout), 16'hBEEF);
    cyc(1, 1, 0, 1, 0, 0, 0);

    // R4: fill endpoint 2, extra write ignored, commit on same edge
    for (int i = 0; i < D; i++) cyc(1, 0, 1, 0, 0, 2, 16'h1000 + 16'(i));
    chk(full == 1'b1, "R4", "full after DEPTH writes", int'(full), 1);
    cyc(1, 0, 1, 0, 1, 2, 16'hDEAD);
    for (int i = 0; i < D; i++) begin
      cyc(1, 0, 0, 1, 0, 2, 0);
      chk(dout == 16'h1000 + 16'(i), "R4", "stored word", int'(dout), 16'h1000 + i);
      cyc(1, 1, 0, 1, 0, 2, 0);
    end
    chk(empty == 1'b1, "R4", "no extra word", int'(empty), 1);
    // R5: reads on empty move nothing
    cyc(1, 1, 0, 0, 0, 2, 0);
    cyc(1, 1, 0, 0, 0, 2, 0);
    cyc(1, 0, 1, 0, 1, 2, 16'h7777);
    cyc(1, 0, 0, 1, 0, 2, 0);
    chk(dout == 16'h7777, "R5", "pointer held on empty read", int'(dout), 16'h7777);
    cyc(1, 1, 0, 0, 0, 2, 0);

    // R2: strobes without select do nothing
    cyc(0, 0, 1, 1, 1, 3, 16'h4444);
    cyc(0, 0, 1, 0, 0, 3, 16'h4444);
    cyc(1, 0, 0, 0, 1, 3, 0);
    chk(empty == 1'b1, "R2", "unselected write dropped", int'(empty), 1);

    // R1: endpoint 0 traffic leaves endpoint 3 alone
    cyc(1, 0, 1, 0, 1, 0, 16'h0123);
    cyc(1, 0, 0, 0, 0, 3, 0);
    chk(empty == 1'b1, "R1", "other endpoint untouched", int'(empty), 1);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk(empty == 1'b0, "R1", "addressed endpoint holds", int'(empty), 0);

    // random synchronous traffic, several strobes per edge
    for (int n = 0; n < 3000; n++) begin
      bit s, r, w, o, p;
      s = ($urandom % 100) < 85;
      r = ($urandom % 100) < 40;
      w = ($urandom % 100) < 45;
      o = ($urandom % 100) < 35;
      p = ($urandom % 100) < 15;
      cyc(s, r, w, o, p, int'($urandom % 4), 16'($urandom));
    end

    // drain endpoint 0 in sync mode before async tests
    for (int i = 0; i < D + 2; i++) cyc(1, 1, 0, 0, 1, 0, 0);
    chk(empty == 1'b1, "R5", "endpoint 0 drained", int'(empty), 1);

    // R9: asynchronous strobes, one transfer each regardless of length
    async_mode = 1'b1;
    astrobe(1, 0, 16'h1111, 5);
    chk(empty == 1'b1, "R9", "async write uncommitted", int'(empty), 1);
    astrobe(1, 0, 16'h2222, 1);
    astrobe(2, 0, 16'h0, 3);
    chk(empty == 1'b0, "R9", "async commit", int'(empty), 0);
    cyc(1, 0, 0, 1, 0, 0, 0);
    chk(dout == 16'h1111, "R9", "async first word", int'(dout), 16'h1111);
    astrobe(0, 0, 16'h0, 6);
    chk(dout == 16'h2222, "R9", "async single advance", int'(dout), 16'h2222);
    astrobe(0, 0, 16'h0, 2);
    chk(empty == 1'b1, "R9", "async drained", int'(empty), 1);
    async_mode = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, 0);

    summary();
    $finish;
  end
endmodule